// File: doc/BRIEF.md
# Isolating General-Purpose I/O Port

This block is an eight-bit bidirectional port for a microcontroller. Software controls it through three small registers on a simple read/write bus. A direction register picks output or input for each bit. An output latch holds the values to drive. An input-enable register decides, bit by bit, whether the digital input path is open. Each pad gets a drive value, a per-bit output enable for its tri-state buffer, and the raw pin level back. Every pin level passes through a two-flop synchronizer before it reaches the read path.

Reading the data register returns the live, synchronized pin levels and never the latch contents. Writes always land in the latch, whatever the direction, and the latch has no reset, so its value survives a reset. A bit whose input-enable is set reads as 0. This lets a pin shared with an analog or interrupt function avoid disturbing the digital path.

For low-power modes, a standby-active input and a pin-state-select bit together request isolation. While isolation is in force, every output enable is held off. Every synchronized input except one exempt bit (bit 4 by default) is clamped to 0, which keeps floating inputs from leaking. Both conditions are sampled on the clock, so entering and leaving isolation each take effect one cycle after the inputs change.

Top module: `gpio_port_isol`

## Requirements
- R1: Outside isolation, pad_oe bit i is 1 exactly when direction bit i is 1 (a direction bit of 1 means output). A direction bit of 0 leaves that pad's output enable at 0, so the pin is high impedance.
- R2: A bus write to address 0 loads bus_wdata into the output latch on that clock edge, whatever the direction bits hold. pad_out shows the latch contents from the next cycle onward.
- R3: A read of address 0 returns the pin levels delayed by two clock edges, gated by input-enable and clamp. The output latch contents are never returned.
- R4: While rst_n is low, the direction register clears to all zeros, so pad_oe is 0 from the first clock edge in reset.
- R5: Reset leaves the output latch unchanged. The value written before reset is still on pad_out afterwards.
- R6: The input-enable register resets to all ones and reads back at address 2. Read-data bit i at address 0 is 0 whenever input-enable bit i is 1.
- R7: When stby_active and pin_hold_sel are both 1 at a clock edge, pad_oe is all zeros in the following cycle, whatever the direction bits hold.
- R8: During isolation, every bit of the address-0 read except bit 4 reads 0. Bit 4 keeps passing its synchronized pin level, subject only to its input-enable bit.
- R9: When stby_active or pin_hold_sel is 0 at a clock edge, pad_oe equals the direction register in the following cycle.
- R10: Address 1 reads back the direction register and address 2 the input-enable register. Address 3 reads as 0. A write to address 3 changes no register.
- R11: stby_active alone, with pin_hold_sel at 0, neither disables the outputs nor clamps the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 input enable |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_out | output | 8 | Drive value for each pad, taken from the output latch |
| pad_oe | output | 8 | Per-pad output enable |
| pad_in | input | 8 | Raw pin levels |
| stby_active | input | 1 | Stop or watch mode is active |
| pin_hold_sel | input | 1 | Selects high-impedance pins and clamped inputs during standby |

## Verification
The bench writes to the latch while the pins are inputs and then turns on output. A latch gated by direction would show a stale value here. It checks that a reset between a write and the readback keeps the written value; a latch placed in the reset branch would lose it. It compares data reads against the pins using a different pattern from the latch, so a read mux that returns the latch, or skips a synchronizer stage, shows a wrong value or the wrong cycle. It enters and leaves isolation with pin_hold_sel both low and high, and watches bit 4. A design that clamped the exempt bit, ignored the select bit, or released the output enables late would read or drive the wrong value in the cycle after the change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_IEN  = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;

    function automatic logic is_reg(input logic [1:0] addr, input gpio_reg_e which);
        return addr == 2'(which);
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wr_addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] ien_o,
    output logic [WIDTH-1:0] latch_o
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] ien;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [WIDTH-1:0] latch_d, latch_q;

    always_comb begin
        cfg_d   = cfg_q;
        latch_d = latch_q;
        if (wr_en) begin
            if (is_reg(wr_addr, REG_DIR)) cfg_d.dir = wr_data;
            if (is_reg(wr_addr, REG_IEN)) cfg_d.ien = wr_data;
            if (is_reg(wr_addr, REG_DATA)) latch_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.dir <= '0;
            cfg_q.ien <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Output latch deliberately carries no reset.
    always_ff @(posedge clk) begin
        latch_q <= latch_d;
    end

    assign dir_o   = cfg_q.dir;
    assign ien_o   = cfg_q.ien;
    assign latch_o = latch_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign pin_sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int WIDTH      = 8,
    parameter int EXEMPT_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_i,
    input  logic             hold_sel_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] ien_i,
    input  logic [WIDTH-1:0] pin_sync_i,
    output logic [WIDTH-1:0] oe_o,
    output logic [WIDTH-1:0] din_o
);

    typedef struct packed {
        logic iso;
    } pad_t;

    pad_t pad_d, pad_q;

    always_comb begin
        pad_d     = pad_q;
        pad_d.iso = stby_i & hold_sel_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pad_q <= '0;
        else        pad_q <= pad_d;
    end

    assign oe_o = pad_q.iso ? '0 : dir_i;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == EXEMPT_BIT) begin : g_exempt
            assign din_o[b] = pin_sync_i[b] & ~ien_i[b];
        end else begin : g_clamped
            assign din_o[b] = pin_sync_i[b] & ~ien_i[b] & ~pad_q.iso;
        end
    end

endmodule

// File: rtl/gpio_port_isol.sv
module gpio_port_isol
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int EXEMPT_BIT  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] pad_in,
    input  logic             stby_active,
    input  logic             pin_hold_sel
);

    logic [WIDTH-1:0] dir_w, ien_w, latch_w, sync_w, din_w;

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (bus_addr),
        .wr_en   (bus_we),
        .wr_data (bus_wdata),
        .dir_o   (dir_w),
        .ien_o   (ien_w),
        .latch_o (latch_w)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pad_in),
        .pin_sync_o (sync_w)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH), .EXEMPT_BIT(EXEMPT_BIT)) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_i     (stby_active),
        .hold_sel_i (pin_hold_sel),
        .dir_i      (dir_w),
        .ien_i      (ien_w),
        .pin_sync_i (sync_w),
        .oe_o       (pad_oe),
        .din_o      (din_w)
    );

    always_comb begin
        unique case (bus_addr)
            2'(REG_DATA): bus_rdata = din_w;
            2'(REG_DIR):  bus_rdata = dir_w;
            2'(REG_IEN):  bus_rdata = ien_w;
            default:      bus_rdata = '0;
        endcase
    end

    assign pad_out = latch_w;

endmodule

// File: rtl/gpio_port_isol_chk.sv
module gpio_port_isol_chk #(
    parameter int WIDTH      = 8,
    parameter int EXEMPT_BIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_we,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic             stby_active,
    input logic             pin_hold_sel
);

    localparam logic [WIDTH-1:0] KEEP_MASK = WIDTH'(1) << EXEMPT_BIT;

    p_reset_oe_r4: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0));

    p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> (pad_out == $past(bus_wdata)));

    p_iso_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_active && pin_hold_sel) |=> (pad_oe == '0));

    p_iso_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_active && pin_hold_sel) |=>
            (bus_addr != 2'd0 || (bus_rdata & ~KEEP_MASK) == '0));

    p_oe_follows_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stby_active && pin_hold_sel) && bus_addr == 2'd1 && !bus_we) |=>
            (pad_oe == $past(bus_rdata)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

bind gpio_port_isol gpio_port_isol_chk #(.WIDTH(WIDTH), .EXEMPT_BIT(EXEMPT_BIT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .stby_active  (stby_active),
    .pin_hold_sel (pin_hold_sel)
);

// File: tb/gpio_port_isol_tb_top.sv
module gpio_port_isol_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pad_in;
    logic       stby_active;
    logic       pin_hold_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    gpio_port_isol dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_in(pad_in), .stby_active(stby_active),
        .pin_hold_sel(pin_hold_sel)
    );

    // Behavioural reference model
    logic [7:0] m_dir, m_ien, m_lat, m_s1, m_s2;
    bit         m_iso, m_lat_ok = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 8'h00; m_ien = 8'hFF; m_iso = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (bus_we && bus_addr == 2'd1) m_dir = bus_wdata;
            if (bus_we && bus_addr == 2'd2) m_ien = bus_wdata;
            m_iso = stby_active && pin_hold_sel;
            m_s2  = m_s1;
            m_s1  = pad_in;
        end
        if (bus_we && bus_addr == 2'd0) begin
            m_lat = bus_wdata; m_lat_ok = 1;
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            2'd0: return m_s2 & ~m_ien & (m_iso ? 8'h10 : 8'hFF);
            2'd1: return m_dir;
            2'd2: return m_ien;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done && rst_n === 1'b1) begin
            check(m_iso ? "R7" : "R1", pad_oe, m_iso ? 8'h00 : m_dir);
            if (m_lat_ok) check("R2", pad_out, m_lat);
            case (bus_addr)
                2'd0: check(m_iso ? "R8" : "R3", bus_rdata, exp_rdata());
                2'd3: check("R10", bus_rdata, exp_rdata());
                default: check("R10", bus_rdata, exp_rdata());
            endcase
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1; step(); bus_we = 0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
        bus_addr = a; @(negedge clk); check(req, bus_rdata, exp); step();
    endtask

    task automatic oe_check(string req, logic [7:0] exp);
        @(negedge clk); check(req, pad_oe, exp); step();
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 0; bus_addr = 0; bus_we = 0; bus_wdata = 0;
        pad_in = 8'h00; stby_active = 0; pin_hold_sel = 0;
        repeat (3) step();
        @(negedge clk); check("R4", pad_oe, 8'h00);
        rst_n = 1; step();
        rd_check("R4", 2'd1, 8'h00);
        rd_check("R6", 2'd2, 8'hFF);

        // R2: latch loads while pins are inputs
        wr(2'd0, 8'hA5);
        @(negedge clk); check("R2", pad_out, 8'hA5); check("R1", pad_oe, 8'h00); step();
        wr(2'd1, 8'hF0);
        oe_check("R1", 8'hF0);

        // R6: input enable masks the data read
        pad_in = 8'h3C; step(); step();
        rd_check("R6", 2'd0, 8'h00);
        wr(2'd2, 8'h0F);
        rd_check("R6", 2'd0, 8'h30);
        wr(2'd2, 8'h00);
        rd_check("R3", 2'd0, 8'h3C);

        // R3: two-edge latency, latch never returned
        bus_addr = 2'd0; pad_in = 8'hC3; step();
        @(negedge clk); check("R3", bus_rdata, 8'h3C); step();
        @(negedge clk); check("R3", bus_rdata, 8'hC3); step();

        // R11: standby without select changes nothing
        wr(2'd1, 8'hFF);
        stby_active = 1; step();
        oe_check("R11", 8'hFF);
        rd_check("R11", 2'd0, 8'hC3);

        // R7/R8: isolation
        pin_hold_sel = 1; pad_in = 8'hFF; step(); step();
        oe_check("R7", 8'h00);
        rd_check("R8", 2'd0, 8'h10);
        pad_in = 8'hEF; step(); step();
        rd_check("R8", 2'd0, 8'h00);

        // R9: leave isolation, enables return the next cycle
        stby_active = 0; step();
        @(negedge clk); check("R9", pad_oe, 8'hFF); step();
        rd_check("R9", 2'd0, 8'hEF);
        stby_active = 1; step();
        oe_check("R7", 8'h00);
        pin_hold_sel = 0; step();
        @(negedge clk); check("R9", pad_oe, 8'hFF); step();
        stby_active = 0;

        // R10: unmapped address
        wr(2'd3, 8'h55);
        rd_check("R10", 2'd3, 8'h00);
        rd_check("R10", 2'd1, 8'hFF);
        rd_check("R10", 2'd2, 8'h00);

        // R5: latch survives reset
        wr(2'd0, 8'h5A);
        rst_n = 0; step(); step();
        @(negedge clk); check("R4", pad_oe, 8'h00); check("R5", pad_out, 8'h5A); step();
        rst_n = 1; step();
        @(negedge clk); check("R5", pad_out, 8'h5A); step();
        rd_check("R6", 2'd2, 8'hFF);

        // Mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_addr     = lfsr[1:0];
            bus_we       = (lfsr[4:2] == 3'd0);
            bus_wdata    = lfsr[15:8];
            pad_in       = lfsr[12:5];
            stby_active  = lfsr[13] & lfsr[6];
            pin_hold_sel = lfsr[14] | lfsr[3];
            step();
        end
        bus_we = 0;
        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule